// File: doc/BRIEF.md
# Cycle-Slip Lock Detector

This block reports whether a phase-locked loop holds lock. It watches one-cycle edge pulses from the reference clock and from the feedback clock, both already brought into the timing-clock domain. A small phase tracker notes which clock is ahead. A cycle slip is flagged when one clock gets a full cycle ahead of the other. After a slip the tracker re-centres.

Every slip, and every cycle in which calibration is running, raises the loss-of-lock output and restarts a quiet-interval timer. The output clears once three things hold: no slip has come for longer than a retrigger time, calibration has ended, and the output has been high for a guaranteed minimum number of cycles. The retrigger time is looked up from a loop-bandwidth code. Narrower bandwidths give longer times, and each step halves or doubles the time.

The asynchronous reset is released through a two-stage synchronizer. While reset is active the detector reports loss of lock. It keeps reporting loss of lock until a first full quiet interval has passed.

Top module: `lock_slip_detector`

## Requirements
- R1: While `rst_n` is low, `lol` is 1 and `slip` is 0. Internal reset ends on the second clock edge after `rst_n` rises, so the third edge is the first functional edge.
- R2: If a reference pulse arrives alone while the reference is already one pulse ahead, `slip` is high for exactly the cycle after that edge.
- R3: If a feedback pulse arrives alone while the feedback is already one pulse ahead, `slip` is high for exactly the cycle after that edge.
- R4: A cycle with both pulses high, or with neither, leaves the phase lead unchanged and never produces a slip.
- R5: A slip re-centres the phase lead to zero, so a slip is never high in two consecutive cycles. The next single pulse after a slip gives no slip.
- R6: `lol` is 1 in the cycle after any cycle in which `slip` is 1.
- R7: Let R be the retrigger count. `lol` clears on the (R+2)th edge after the edge that raised `slip`, provided no further slip or calibration occurs and the R8 limit has passed.
- R8: Each time `lol` rises, it stays 1 for at least MIN_PW+1 cycles. With the default values (MIN_PW=60 and R=20 or 40) it stays 1 for exactly 61 cycles.
- R9: `lol` is 1 in every cycle after an edge that sampled `cal_busy` high. The quiet interval restarts on every such edge.
- R10: After reset with no slip, `lol` first reads 0 max(R, MIN_PW)+3 cycles after `rst_n` rises.
- R11: R = BASE_TICKS·2^(6−k), where k is `bw_code` limited to 6. Code 0 is the narrowest bandwidth and gives the longest time. Code 7 acts as code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One-cycle pulse per reference clock edge |
| fb_pulse | input | 1 | One-cycle pulse per feedback clock edge |
| bw_code | input | CODE_W | Loop-bandwidth code selecting the retrigger count |
| cal_busy | input | 1 | High while calibration runs |
| slip | output | 1 | One-cycle pulse on each detected cycle slip |
| lol | output | 1 | Loss-of-lock indication, active high |

## Verification
Two release conditions can fall due on the same edge: the quiet interval expires while a new slip or a calibration sample arrives. The end of the minimum pulse can likewise coincide with the end of the quiet interval. Random pulse trains with several bandwidth codes, together with single calibration cycles, bring these cases together. Every cycle is then compared against a model built from the requirements, which decides which condition wins. Directed single slips at each code measure the exact high time of `lol`, so the bench can tell whether the retrigger count or the minimum pulse width set that time.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [1:0] {
    PH_EVEN   = 2'b00,
    PH_REF_UP = 2'b01,
    PH_FB_UP  = 2'b11
  } phase_e;
endpackage

// File: rtl/lsd_phase_tracker.sv
module lsd_phase_tracker
  import lsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic fb_i,
  output logic slip_o
);
  phase_e phase_q, phase_n;
  logic   slip_q, slip_n;

  always_comb begin
    phase_n = phase_q;
    slip_n  = 1'b0;
    if (ref_i && !fb_i) begin
      case (phase_q)
        PH_REF_UP: begin slip_n = 1'b1; phase_n = PH_EVEN; end
        PH_FB_UP:  phase_n = PH_EVEN;
        default:   phase_n = PH_REF_UP;
      endcase
    end else if (fb_i && !ref_i) begin
      case (phase_q)
        PH_FB_UP:  begin slip_n = 1'b1; phase_n = PH_EVEN; end
        PH_REF_UP: phase_n = PH_EVEN;
        default:   phase_n = PH_FB_UP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_EVEN;
      slip_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      slip_q  <= slip_n;
    end
  end

  assign slip_o = slip_q;

  AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |=> !slip_o); // R5
  AST_SLIP_LONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |-> $past(ref_i ^ fb_i)); // R4
endmodule

// File: rtl/lsd_retrig_lut.sv
module lsd_retrig_lut #(
  parameter int BASE_TICKS = 20,
  parameter int NUM_CODES  = 7,
  parameter int CODE_W     = 3,
  parameter int CNT_W      = 13
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  retrig_o
);
  localparam int MAX_CODE = NUM_CODES - 1;

  logic [CNT_W-1:0]  table_w [NUM_CODES];
  logic [CODE_W-1:0] idx;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
    assign table_w[g] = CNT_W'(BASE_TICKS) << (MAX_CODE - g);
  end

  always_comb begin
    if (code_i > CODE_W'(MAX_CODE)) idx = CODE_W'(MAX_CODE);
    else                            idx = code_i;
    retrig_o = table_w[idx];
  end
endmodule

// File: rtl/lsd_lol_timer.sv
module lsd_lol_timer #(
  parameter int CNT_W  = 13,
  parameter int MIN_PW = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slip_i,
  input  logic             cal_i,
  input  logic [CNT_W-1:0] retrig_i,
  output logic             lol_o
);
  localparam int PW_W = $clog2(MIN_PW + 1) + 1;

  logic [CNT_W-1:0] ivl_q, ivl_n;
  logic [PW_W-1:0]  pw_q, pw_n;
  logic             lol_q, lol_n;
  logic             ivl_done, pw_done, restart;

  assign ivl_done = (ivl_q >= retrig_i);
  assign pw_done  = (pw_q >= PW_W'(MIN_PW));
  assign restart  = slip_i | cal_i;

  always_comb begin
    lol_n = restart | (lol_q & ~(ivl_done & pw_done));
    if (restart)       ivl_n = '0;
    else if (ivl_done) ivl_n = ivl_q;
    else               ivl_n = ivl_q + CNT_W'(1);
    if (lol_n && !lol_q)      pw_n = '0;
    else if (lol_q && !pw_done) pw_n = pw_q + PW_W'(1);
    else                      pw_n = pw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
      pw_q  <= '0;
      lol_q <= 1'b1;
    end else begin
      ivl_q <= ivl_n;
      pw_q  <= pw_n;
      lol_q <= lol_n;
    end
  end

  assign lol_o = lol_q;

  AST_LOL_AFTER_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    slip_i |=> lol_o); // R6
  AST_CAL_HOLDS_LOL: assert property (@(posedge clk) disable iff (!rst_n)
    cal_i |=> lol_o); // R9
  AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol_o) |-> ($past(pw_q) >= PW_W'(MIN_PW))); // R8
  AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol_o) |-> ($past(ivl_q) >= $past(retrig_i))); // R7
endmodule

// File: rtl/lock_slip_detector.sv
module lock_slip_detector #(
  parameter int BASE_TICKS = 20,
  parameter int NUM_CODES  = 7,
  parameter int CODE_W     = 3,
  parameter int MIN_PW     = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pulse,
  input  logic              fb_pulse,
  input  logic [CODE_W-1:0] bw_code,
  input  logic              cal_busy,
  output logic              slip,
  output logic              lol
);
  localparam int CNT_W = $clog2(BASE_TICKS + 1) + NUM_CODES + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] retrig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lsd_phase_tracker u_track (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ref_i  (ref_pulse),
    .fb_i   (fb_pulse),
    .slip_o (slip)
  );

  lsd_retrig_lut #(
    .BASE_TICKS (BASE_TICKS),
    .NUM_CODES  (NUM_CODES),
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W)
  ) u_lut (
    .code_i   (bw_code),
    .retrig_o (retrig)
  );

  lsd_lol_timer #(
    .CNT_W  (CNT_W),
    .MIN_PW (MIN_PW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .slip_i   (slip),
    .cal_i    (cal_busy),
    .retrig_i (retrig),
    .lol_o    (lol)
  );
endmodule

// File: tb/lock_slip_detector_tb.sv
module lock_slip_detector_tb;
  localparam int BASE = 20;
  localparam int MINPW = 60;

  logic clk = 1'b0;
  logic rst_n, ref_pulse, fb_pulse, cal_busy;
  logic [2:0] bw_code;
  logic slip, lol;

  int errors = 0, checks = 0;
  bit done = 0;

  int m_diff, m_ivl, m_pw, m_hold;
  bit m_slip, m_lol;
  int run, last_width;
  bit prev_lol;

  always #10 clk = ~clk;

  lock_slip_detector u_dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .bw_code(bw_code), .cal_busy(cal_busy), .slip(slip), .lol(lol)
  );

  function automatic int retrig_of(input int code);
    int k;
    k = (code > 6) ? 6 : code;
    return BASE << (6 - k);
  endfunction

  task automatic chk(input bit ok, input string tg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  task automatic model_reset();
    m_diff = 0; m_ivl = 0; m_pw = 0; m_slip = 0; m_lol = 1;
  endtask

  task automatic model_step(input bit r, input bit f, input bit c);
    int rt, ivl_n, pw_n, diff_n;
    bit slip_n, lol_n, ivd, pwd;
    if (m_hold > 0) begin
      m_hold--;
      return;
    end
    slip_n = 0; diff_n = m_diff;
    if (r && !f) begin
      if (m_diff == 1) begin slip_n = 1; diff_n = 0; end else diff_n = m_diff + 1;
    end else if (f && !r) begin
      if (m_diff == -1) begin slip_n = 1; diff_n = 0; end else diff_n = m_diff - 1;
    end
    rt  = retrig_of(int'(bw_code));
    ivd = (m_ivl >= rt);
    pwd = (m_pw >= MINPW);
    lol_n = c || m_slip || (m_lol && !(ivd && pwd));
    ivl_n = (m_slip || c) ? 0 : (ivd ? m_ivl : m_ivl + 1);
    pw_n  = (lol_n && !m_lol) ? 0 : ((m_lol && !pwd) ? m_pw + 1 : m_pw);
    m_diff = diff_n; m_slip = slip_n; m_lol = lol_n; m_ivl = ivl_n; m_pw = pw_n;
  endtask

  // Called at a negedge: compare, drive, advance the model, wait for the next negedge.
  task automatic cyc(input bit r, input bit f, input bit c, input string tg);
    chk(slip == m_slip, {tg, " slip"}, int'(slip), int'(m_slip));
    chk(lol == m_lol, {tg, " lol"}, int'(lol), int'(m_lol));
    if (lol) run++;
    else if (prev_lol) begin last_width = run; run = 0; end
    prev_lol = lol;
    ref_pulse = r; fb_pulse = f; cal_busy = c;
    model_step(r, f, c);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tg);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, tg);
  endtask

  task automatic one_slip(input int code, input int exp_w, input string tg);
    bw_code = 3'(code);
    idle(5, tg);
    cyc(1, 0, 0, tg);
    cyc(1, 0, 0, tg);
    idle(exp_w + 20, tg);
    chk(last_width == exp_w, {tg, " lol width"}, last_width, exp_w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; ref_pulse = 0; fb_pulse = 0; cal_busy = 0; bw_code = 3'd6;
    model_reset(); m_hold = 0; run = 0; last_width = 0; prev_lol = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      ref_pulse = (i == 1); fb_pulse = (i == 2);
      @(negedge clk);
      chk(lol == 1'b1, "R1 lol in reset", int'(lol), 1);
      chk(slip == 1'b0, "R1 slip in reset", int'(slip), 0);
    end
    ref_pulse = 0; fb_pulse = 0;
    rst_n = 1; m_hold = 2; run = 0;
    idle(90, "R10");
    chk(last_width == MINPW + 3, "R10 release after reset", last_width, MINPW + 3);

    // Phase tracker directed cases
    cyc(1, 0, 0, "R2"); cyc(1, 0, 0, "R2");
    chk(slip == 1'b1, "R2 ref lead slip", int'(slip), 1);
    cyc(0, 0, 0, "R5");
    chk(slip == 1'b0, "R5 single-cycle slip", int'(slip), 0);
    chk(lol == 1'b1, "R6 lol after slip", int'(lol), 1);
    cyc(1, 0, 0, "R5"); cyc(0, 0, 0, "R5");
    chk(slip == 1'b0, "R5 re-centred", int'(slip), 0);
    cyc(1, 1, 0, "R4"); cyc(1, 1, 0, "R4"); cyc(0, 0, 0, "R4");
    chk(slip == 1'b0, "R4 paired pulses", int'(slip), 0);
    cyc(0, 1, 0, "R3"); cyc(0, 1, 0, "R3"); cyc(0, 1, 0, "R3");
    chk(slip == 1'b1, "R3 fb lead slip", int'(slip), 1);
    idle(150, "R7");

    // Release timing per code
    one_slip(4, retrig_of(4) + 1, "R7");
    one_slip(5, MINPW + 1, "R8");
    one_slip(6, MINPW + 1, "R8");
    one_slip(0, retrig_of(0) + 1, "R11");
    one_slip(7, MINPW + 1, "R11");

    // Calibration override
    bw_code = 3'd6;
    idle(10, "R9");
    for (int i = 0; i < 50; i++) cyc(0, 0, 1, "R9");
    chk(lol == 1'b1, "R9 lol during cal", int'(lol), 1);
    idle(100, "R9");
    chk(last_width == 70, "R9 width after cal", last_width, 70);

    // Frequency offset: reference faster than feedback
    for (int i = 0; i < 2000; i++) cyc((i % 10) == 0, (i % 11) == 0, 0, "R6");
    // Equal frequencies with fixed phase offset
    for (int i = 0; i < 1000; i++) cyc((i % 10) == 0, (i % 10) == 3, 0, "R7");
    chk(lol == 1'b0, "R7 locked at equal frequency", int'(lol), 0);

    // Constrained random mix
    for (int i = 0; i < 5000; i++) begin
      if ((i % 500) == 0) bw_code = 3'(4 + ($urandom % 4));
      cyc(($urandom % 9) == 0, ($urandom % 9) == 0, ($urandom % 400) == 0, "R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule